// File: doc/BRIEF.md
# Edge-Triggered Status Interrupt Collector

This block watches a set of level status lines coming from analog detectors: three supply-bus comparators, a charger-present line, two identification-pin comparators, a single-ended-one line detector, an over-voltage comparator, a reverse-charge event and a constant-current/constant-voltage transition. Each line is brought into the clock domain through a two-stage synchronizer. The block raises a sticky flag whenever a line changes level, in either direction. Several raw lines feed one shared flag: the three bus comparators share one, and the two identification comparators share another. The processor sees a single interrupt line. That line is high while any flag is set whose mask bit is clear.

The charger-present line goes through a debounce filter, and the other lines do not. The filter counts pulses of a slow tick input. The period is selectable from 1, 2, 4 or 8 ticks. A power-domain input tells the block whether the regulator that feeds most of the detectors is on. While it is off, only the charger-present and identification sources can raise flags. The processor reads the synchronized levels, the flags and the mask as three words. It writes the mask directly and clears flags by writing ones.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous active-low reset, every flag is 0, every mask bit is 1, the sense word is 0 and `irq_o` is low.
- R2: Flag bit 0 is set by a rising or a falling change on any of raw bits 0, 1 or 2 (the bus-voltage comparators).
- R3: Flag bit 2 is set each time the two-bit identification status on raw bits 4 and 5 changes value, including when both bits change together.
- R4: Raw bits 6, 7, 8 and 9 set flag bits 3, 4, 5 and 6 respectively, on either edge and without debounce. The flag is visible no later than the third clock edge after the raw change.
- R5: A write with `wr_addr_i` = 0 clears every flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R6: A write with `wr_addr_i` = 1 loads the mask. `irq_o` is high exactly when some flag is 1 and its mask bit is 0. Masked flags still latch.
- R7: When the last unmasked flag is cleared, `irq_o` is low in the same cycle that the flag reads 0.
- R8: If a source event and a clear of the same flag occur in the same cycle, the flag stays set.
- R9: Raw bit 3 (charger present) sets flag bit 1 only after its new level has held for 2^`dbnc_sel_i` tick pulses. A change that reverts sooner raises no flag and leaves sense bit 3 unchanged.
- R10: While `dom_on_i` is 0, only flag bits 1 and 2 can be set. Changes on other sources are dropped, and raise no flag when the domain returns.
- R11: Sense bit i shows the synchronized level of raw bit i, after debounce for bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Slow tick pulse for the debounce counters |
| dbnc_sel_i | input | DBNC_SEL_W | Debounce period select, 2^value ticks |
| dom_on_i | input | 1 | Detector power domain is on |
| raw_i | input | 10 | Raw detector levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = flag clear word, 1 = mask word |
| wr_data_i | input | 7 | Write data |
| sense_o | output | 10 | Synchronized and filtered levels |
| flag_o | output | 7 | Latched change flags |
| mask_o | output | 7 | Mask word, 1 = source masked |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench toggles every raw line in both directions and checks that exactly the shared flag for its group rises. A design that caught only rising edges, or that mapped a comparator to the wrong flag, fails this sweep. It arranges for a clear write to hit the same cycle as a fresh event, which catches a clear-wins priority. It sweeps all four debounce periods with a glitch one tick short and then a change of full length, which exposes off-by-one counters. It also drops events from sources outside the always-on set while the domain is off, and then restores the domain to catch a late spurious flag.

// File: rtl/irq_agg_pkg.sv
// Package: constants and source-to-flag mapping shared by the collector.
// Assumes raw line order is fixed as documented in the brief.
package irq_agg_pkg;
    localparam int RAW_W  = 10;
    localparam int NFLAG  = 7;
    // raw lines that pass through the debounce filter
    localparam logic [RAW_W-1:0] DBNC_RAW = 10'b00_0000_1000;
    // flags that can be raised while the detector domain is off
    localparam logic [NFLAG-1:0] AON_FLAG = 7'b000_0110;

    // Flag index that a raw line feeds.
    function automatic int flag_of(input int r);
        case (r)
            0, 1, 2: return 0;
            3:       return 1;
            4, 5:    return 2;
            6:       return 3;
            7:       return 4;
            8:       return 5;
            default: return 6;
        endcase
    endfunction
endpackage

// File: rtl/sync2.sv
// Module: two-stage synchronizer for a vector of independent level lines.
// Assumes each bit is a slow level; no bus coherency is implied.
module sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // two flops per bit, synchronous reset to 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/dbnc_cell.sv
// Module: tick-based debounce for one synchronized level.
// The output follows the input once the input has differed from it for
// 2^sel consecutive tick pulses; any return to the output level restarts.
// Assumes tick_i is a single-cycle pulse.
module dbnc_cell #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             d_i,
    output logic             lvl_o
);
    localparam int CNT_W = 2 ** SEL_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    // period in ticks from the select value
    always_comb lim = CNT_W'(1) << sel_i;

    // count ticks while input differs, commit at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_o <= 1'b0;
            cnt_q <= '0;
        end else if (d_i == lvl_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == lim - CNT_W'(1)) begin
                lvl_o <= d_i;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // R9: the filtered level only moves on a tick
    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(lvl_o));
endmodule

// File: rtl/flag_bank.sv
// Module: sticky flags with write-one-to-clear, mask word and interrupt.
// A set in the same cycle as a clear wins. Assumes set_i is one cycle wide.
module flag_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_wr_i,
    input  logic         msk_wr_i,
    input  logic [N-1:0] data_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);
    logic [N-1:0] clr_vec;

    // clear vector active only on a flag-word write
    always_comb clr_vec = clr_wr_i ? data_i : '0;

    // flag update: clear then set, so set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= '0;
        else        flag_o <= (flag_o & ~clr_vec) | set_i;
    end

    // mask register, all sources masked out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_o <= '1;
        else if (msk_wr_i) mask_o <= data_i;
    end

    // interrupt from unmasked pending flags
    always_comb irq_o = |(flag_o & ~mask_o);

    // R8: an event always leaves its flag set
    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));
    // R5: written ones clear flags without a simultaneous event
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_i |=> ((flag_o & $past(data_i) & ~$past(set_i)) == '0));
    // R5: without a clear write no flag drops
    p_no_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr_i |=> ((flag_o & $past(flag_o)) == $past(flag_o)));
    // R6: interrupt implies some flag pending
    p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_o != '0));
    // R6: fully masked bank never interrupts
    p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '1) |-> !irq_o);
endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the status interrupt collector.
// Synchronizes raw detector lines, debounces the selected ones, detects
// changes in both directions, merges lines into shared flags, gates
// sources that lose power and drives the flag bank.
// Assumes raw_i levels are asynchronous and slow against clk.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int DBNC_SEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic [DBNC_SEL_W-1:0] dbnc_sel_i,
    input  logic                  dom_on_i,
    input  logic [RAW_W-1:0]      raw_i,
    input  logic                  wr_en_i,
    input  logic                  wr_addr_i,
    input  logic [NFLAG-1:0]      wr_data_i,
    output logic [RAW_W-1:0]      sense_o,
    output logic [NFLAG-1:0]      flag_o,
    output logic [NFLAG-1:0]      mask_o,
    output logic                  irq_o
);
    logic [RAW_W-1:0] sync_lvl;
    logic [RAW_W-1:0] lvl;
    logic [RAW_W-1:0] lvl_q;
    logic [RAW_W-1:0] chg;
    logic [NFLAG-1:0] evt;
    logic [NFLAG-1:0] set_vec;

    sync2 #(.W(RAW_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_i),
        .q_o   (sync_lvl)
    );

    // per-line choice of debounce or bypass
    for (genvar i = 0; i < RAW_W; i++) begin : g_line
        if (DBNC_RAW[i]) begin : g_dbnc
            dbnc_cell #(.SEL_W(DBNC_SEL_W)) u_dbnc (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick_i (tick_i),
                .sel_i  (dbnc_sel_i),
                .d_i    (sync_lvl[i]),
                .lvl_o  (lvl[i])
            );
        end else begin : g_pass
            assign lvl[i] = sync_lvl[i];
        end
    end

    // previous filtered level for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    // merge per-line changes into per-flag events
    always_comb begin
        chg = lvl ^ lvl_q;
        evt = '0;
        for (int r = 0; r < RAW_W; r++) begin
            if (chg[r]) evt[flag_of(r)] = 1'b1;
        end
    end

    // drop events of unpowered sources
    always_comb set_vec = evt & (dom_on_i ? '1 : AON_FLAG);

    always_comb sense_o = lvl;

    flag_bank #(.N(NFLAG)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_wr_i (wr_en_i && !wr_addr_i),
        .msk_wr_i (wr_en_i && wr_addr_i),
        .data_i   (wr_data_i),
        .flag_o   (flag_o),
        .mask_o   (mask_o),
        .irq_o    (irq_o)
    );

    // R10: with the domain off, flags outside the always-on set stay put
    p_domain_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dom_on_i && !wr_en_i) |=>
            ((flag_o & ~AON_FLAG) == ($past(flag_o) & ~AON_FLAG)));
    // R2: a bus comparator change raises the shared flag next cycle
    p_bus_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_on_i && (chg[2:0] != 3'b000)) |=> flag_o[0]);
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
    localparam int RW = 10;
    localparam int NF = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [1:0]    sel = 2'd0;
    logic          dom = 1'b1;
    logic [RW-1:0] raw = '0;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [NF-1:0] wr_data = '0;
    logic [RW-1:0] sense;
    logic [NF-1:0] flag;
    logic [NF-1:0] mask;
    logic          irq;

    int n_run = 0;
    int n_fail = 0;

    always #2ns clk = ~clk;

    irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .dbnc_sel_i(sel),
        .dom_on_i(dom), .raw_i(raw), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .sense_o(sense), .flag_o(flag), .mask_o(mask),
        .irq_o(irq)
    );

    // bench-side mapping of raw line to flag, from the requirements
    function automatic int grp(input int r);
        if (r <= 2) return 0;
        if (r == 3) return 1;
        if (r <= 5) return 2;
        return r - 3;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [NF-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1; step(1); tick = 1'b0; step(1);
        end
    endtask

    initial begin
        #(4ns * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(flag == 0, "R1 flags", flag, 0);
        chk(mask == 7'h7f, "R1 mask", mask, 7'h7f);
        chk(irq == 0 && sense == 0, "R1 irq/sense", {irq, sense}, 0);

        // R2 R3 R4 R11: every undebounced line, both directions
        for (int r = 0; r < RW; r++) begin
            if (r == 3) continue;
            for (int dir = 0; dir < 2; dir++) begin
                raw[r] = ~raw[r];
                step(4);
                chk(flag == (7'd1 << grp(r)), $sformatf("R2/R3/R4 line %0d dir %0d", r, dir),
                    flag, 7'd1 << grp(r));
                chk(sense == raw, "R11 sense", sense, raw);
                chk(irq == 0, "R6 masked irq", irq, 0);
                wr(1'b0, 7'h7f);
                chk(flag == 0, "R5 clear", flag, 0);
            end
        end

        // R3: both ID bits change at once
        raw[5:4] = 2'b11;
        step(4);
        chk(flag == 7'b000_0100, "R3 dual change", flag, 7'b000_0100);
        raw[5:4] = 2'b00;
        step(4);
        wr(1'b0, 7'h7f);

        // R4 timing: visible by third edge
        raw[8] = 1'b1;
        step(3);
        chk(flag[5] == 1'b1, "R4 latency", flag, 7'b010_0000);
        wr(1'b0, 7'h7f);

        // R5: selective clear, zero write no effect
        raw[0] = 1'b0; raw[6] = 1'b1; raw[7] = 1'b1; raw[1] = 1'b1;
        step(4);
        chk(flag == 7'b001_1001, "R5 setup", flag, 7'b001_1001);
        wr(1'b0, 7'b000_1000);
        chk(flag == 7'b001_0001, "R5 partial clear", flag, 7'b001_0001);
        wr(1'b0, 7'b000_0000);
        chk(flag == 7'b001_0001, "R5 zero write", flag, 7'b001_0001);

        // R6 R7: mask and interrupt
        wr(1'b1, 7'b111_1110);
        chk(mask == 7'b111_1110, "R6 mask load", mask, 7'b111_1110);
        chk(irq == 1, "R6 irq unmasked", irq, 1);
        wr(1'b0, 7'b001_0000);
        chk(irq == 1, "R6 irq remains", irq, 1);
        wr(1'b0, 7'b000_0001);
        chk(flag == 0 && irq == 0, "R7 irq drop", {irq, flag}, 0);
        wr(1'b1, 7'h7f);

        // R8: event and clear collide
        raw[7] = 1'b0;
        step(4);
        chk(flag[4] == 1, "R8 setup", flag, 7'b001_0000);
        raw[7] = 1'b1;
        step(2);
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 7'b001_0000;
        step(1);
        wr_en = 1'b0; wr_data = '0;
        chk(flag[4] == 1, "R8 event wins", flag, 7'b001_0000);
        wr(1'b0, 7'h7f);
        step(3);
        chk(flag == 0, "R8 later clear", flag, 0);

        // R10: domain off
        dom = 1'b0;
        raw[7] = 1'b0; raw[2] = 1'b1;
        step(4);
        chk(flag == 0, "R10 dropped", flag, 0);
        raw[4] = 1'b1;
        step(4);
        chk(flag == 7'b000_0100, "R10 ID kept", flag, 7'b000_0100);
        sel = 2'd0;
        raw[3] = 1'b1;
        step(3);
        tick_n(1);
        step(3);
        chk(flag == 7'b000_0110, "R10 charger kept", flag, 7'b000_0110);
        dom = 1'b1;
        step(4);
        chk(flag == 7'b000_0110, "R10 no late flag", flag, 7'b000_0110);
        raw[3] = 1'b0;
        step(3);
        tick_n(1);
        step(3);
        wr(1'b0, 7'h7f);

        // R9: debounce sweep over all periods
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            raw[3] = 1'b1;
            step(3);
            tick_n((1 << s) - 1);
            raw[3] = 1'b0;
            step(3);
            tick_n(2);
            step(3);
            chk(flag == 0, $sformatf("R9 glitch sel %0d", s), flag, 0);
            chk(sense[3] == 0, "R9 glitch sense", sense, 0);
            raw[3] = 1'b1;
            step(3);
            tick_n(1 << s);
            step(3);
            chk(flag == 7'b000_0010, $sformatf("R9 full sel %0d", s), flag, 7'b000_0010);
            chk(sense[3] == 1, "R9 sense after", sense[3], 1);
            raw[3] = 1'b0;
            step(3);
            tick_n(1 << s);
            step(3);
            wr(1'b0, 7'h7f);
        end

        // R9: no ticks means no change
        raw[3] = 1'b1;
        step(20);
        chk(flag == 0 && sense[3] == 0, "R9 no tick", flag, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule